// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block steers instruction fetch in a five-stage in-order pipeline whose branches are resolved in the decode stage. It owns the fetch address register and the fetch-to-decode instruction register. Each cycle it decides the next fetch address, whether the fetch address must be held, and whether the word entering decode must be replaced by the all-zero no-operation word.

The decoder outside the block reports whether the instruction now in decode is a branch, whether its comparison succeeded, and its target address. An external adder supplies the sequential address. A two-bit policy input, fixed while reset is asserted, selects how the hazard is handled. In the stall policy, every branch costs one cycle. In the predict-not-taken policy, only a taken branch costs a cycle. In the delay-slot policy, the instruction after a branch always executes and no cycle is lost.

Top module: `brhz_fetch_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the fetch address is RESET_PC (default 0), the decode word is all-zero, and `pc_sel_o`, `fetch_hold_o` and `dec_flush_o` are low.
- R2: With no branch in decode, the fetch address advances to `seq_pc_i` on each clock, the decode register loads `instr_i`, and all three control outputs stay low.
- R3: Policy codes on `mode_i`: 2'b00 stall, 2'b01 predict not-taken, 2'b10 delay slot, 2'b11 behaves as stall. The code stays unchanged outside reset.
- R4: Stall policy, taken branch: `pc_sel_o`=1, `fetch_hold_o`=0 and `dec_flush_o`=1. The next fetch address is the target, and one cycle is lost.
- R5: Stall policy, untaken branch: `fetch_hold_o`=1, `pc_sel_o`=0 and `dec_flush_o`=1. The fetch address is kept for one cycle so the fall-through word is fetched again, and one cycle is lost.
- R6: Predict-not-taken policy, untaken branch: all control outputs are low, fetch continues sequentially, and no cycle is lost.
- R7: Predict-not-taken policy, taken branch: `pc_sel_o`=1 and `dec_flush_o`=1. The single word fetched after the branch becomes a no-op, and fetch resumes at the target.
- R8: Delay-slot policy: `dec_flush_o` and `fetch_hold_o` stay low whatever the outcome. The word after the branch enters decode. A taken branch redirects fetch to the target right after that slot.
- R9: A flushed decode slot holds the all-zero 32-bit word, so a squashed instruction can write neither a register nor memory.
- R10: `next_pc_o` equals `dec_target_i` when `pc_sel_o` is high and `seq_pc_i` otherwise. `pc_sel_o` and `fetch_hold_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Hazard policy code |
| instr_i | input | INSTR_W | Word fetched at `fetch_pc_o` |
| dec_branch_i | input | 1 | Instruction in decode is a branch |
| dec_taken_i | input | 1 | Branch comparison result |
| dec_target_i | input | ADDR_W | Branch target address |
| seq_pc_i | input | ADDR_W | Sequential address after `fetch_pc_o` |
| fetch_pc_o | output | ADDR_W | Current fetch address |
| dec_instr_o | output | INSTR_W | Word held in the decode register |
| next_pc_o | output | ADDR_W | Selected next fetch address |
| pc_sel_o | output | 1 | Next address comes from the branch target |
| fetch_hold_o | output | 1 | Fetch address held this cycle |
| dec_flush_o | output | 1 | Next decode word replaced by the no-op |

## Verification
The assertions check the following on every cycle:
- hold and redirect are never high together;
- no control output rises without a branch in decode;
- a flush always leaves a zero word in decode;
- a hold keeps the fetch address;
- a redirect or a sequential step lands on the address presented one cycle earlier;
- the delay-slot policy never flushes or holds;
- the policy code is steady outside reset.

Only the bench scenarios show the end-to-end effect of each policy. They cover the whole fetch-address sequence through a taken and an untaken branch, the re-fetch of the fall-through word under the stall policy, the slot instruction surviving in delay mode, and the count of retired non-zero words that measures the lost cycle.

// File: rtl/brhz_pkg.sv
package brhz_pkg;

   localparam int MODE_W   = 2;
   localparam int MODE_CNT = 1 << MODE_W;

   typedef enum logic [MODE_W-1:0] {
      POL_STALL      = 2'b00,
      POL_PREDICT_NT = 2'b01,
      POL_DELAY_SLOT = 2'b10,
      POL_RESERVED   = 2'b11
   } pol_e;

   // What a policy does with the word fetched behind a branch in decode
   typedef struct packed {
      logic squash_taken;     // replace it by a no-op when the branch is taken
      logic squash_fallthru;  // replace it by a no-op when the branch falls through
      logic refetch_fallthru; // keep the fetch address when the branch falls through
   } rule_t;

   function automatic rule_t rule_of(logic [MODE_W-1:0] code);
      rule_t r;
      case (pol_e'(code))
         POL_PREDICT_NT: begin
            r.squash_taken     = 1'b1;
            r.squash_fallthru  = 1'b0;
            r.refetch_fallthru = 1'b0;
         end
         POL_DELAY_SLOT: begin
            r.squash_taken     = 1'b0;
            r.squash_fallthru  = 1'b0;
            r.refetch_fallthru = 1'b0;
         end
         default: begin // stall and the reserved code
            r.squash_taken     = 1'b1;
            r.squash_fallthru  = 1'b1;
            r.refetch_fallthru = 1'b1;
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/brhz_policy.sv
module brhz_policy
   import brhz_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              branch_i,
   input  logic              taken_i,
   input  logic [ADDR_W-1:0] target_i,
   input  logic [ADDR_W-1:0] seq_pc_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              sel_o,
   output logic              hold_o,
   output logic              flush_o
);

   rule_t [MODE_CNT-1:0] rule_tbl;
   rule_t                act;

   for (genvar m = 0; m < MODE_CNT; m++) begin : g_rule
      assign rule_tbl[m] = rule_of(MODE_W'(m));
   end

   assign act = rule_tbl[mode_i];

   always_comb begin
      sel_o   = branch_i & taken_i;
      hold_o  = branch_i & ~taken_i & act.refetch_fallthru;
      flush_o = branch_i & (taken_i ? act.squash_taken : act.squash_fallthru);
      next_pc_o = sel_o ? target_i : seq_pc_i;
   end

endmodule

// File: rtl/brhz_pc_reg.sv
module brhz_pc_reg #(
   parameter int          ADDR_W   = 32,
   parameter int unsigned RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic [ADDR_W-1:0] next_pc_i,
   output logic [ADDR_W-1:0] pc_o
);

   localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o <= PC_INIT;
      end else if (!hold_i) begin
         pc_o <= next_pc_i;
      end
   end

endmodule

// File: rtl/brhz_decode_reg.sv
module brhz_decode_reg #(
   parameter int INSTR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic [INSTR_W-1:0] instr_i,
   output logic [INSTR_W-1:0] instr_o
);

   localparam logic [INSTR_W-1:0] NOP_WORD = '0;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         instr_o <= NOP_WORD;
      end else begin
         instr_o <= instr_i;
      end
   end

endmodule

// File: rtl/brhz_fetch_ctrl.sv
module brhz_fetch_ctrl
   import brhz_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          INSTR_W  = 32,
   parameter int unsigned RESET_PC = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               dec_branch_i,
   input  logic               dec_taken_i,
   input  logic [ADDR_W-1:0]  dec_target_i,
   input  logic [ADDR_W-1:0]  seq_pc_i,
   output logic [ADDR_W-1:0]  fetch_pc_o,
   output logic [INSTR_W-1:0] dec_instr_o,
   output logic [ADDR_W-1:0]  next_pc_o,
   output logic               pc_sel_o,
   output logic               fetch_hold_o,
   output logic               dec_flush_o
);

   if (ADDR_W < 3 || ADDR_W > 64) begin : g_bad_addr_w
      $error("brhz_fetch_ctrl: ADDR_W must lie in 3..64");
   end
   if (INSTR_W < 8) begin : g_bad_instr_w
      $error("brhz_fetch_ctrl: INSTR_W must be at least 8");
   end
   if ((RESET_PC % 4) != 0) begin : g_bad_reset_pc
      $error("brhz_fetch_ctrl: RESET_PC must be word aligned");
   end

   logic sel, hold, flush;
   logic [ADDR_W-1:0] nxt_pc;

   brhz_policy #(.ADDR_W(ADDR_W)) u_policy (
      .mode_i   (mode_i),
      .branch_i (dec_branch_i),
      .taken_i  (dec_taken_i),
      .target_i (dec_target_i),
      .seq_pc_i (seq_pc_i),
      .next_pc_o(nxt_pc),
      .sel_o    (sel),
      .hold_o   (hold),
      .flush_o  (flush)
   );

   brhz_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (hold),
      .next_pc_i(nxt_pc),
      .pc_o     (fetch_pc_o)
   );

   brhz_decode_reg #(.INSTR_W(INSTR_W)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush_i(flush),
      .instr_i(instr_i),
      .instr_o(dec_instr_o)
   );

   assign next_pc_o    = nxt_pc;
   assign pc_sel_o     = sel;
   assign fetch_hold_o = hold;
   assign dec_flush_o  = flush;

endmodule

// File: rtl/brhz_fetch_ctrl_chk.sv
module brhz_fetch_ctrl_chk #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode_i,
   input logic               dec_branch_i,
   input logic [ADDR_W-1:0]  dec_target_i,
   input logic [ADDR_W-1:0]  seq_pc_i,
   input logic [ADDR_W-1:0]  fetch_pc_o,
   input logic [INSTR_W-1:0] dec_instr_o,
   input logic               pc_sel_o,
   input logic               fetch_hold_o,
   input logic               dec_flush_o
);

   // R3: the policy code is static outside reset
   p_mode_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mode_i));

   // R2: no branch in decode, no control action
   p_quiet_without_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_branch_i |-> (!pc_sel_o && !fetch_hold_o && !dec_flush_o));

   // R10: redirect and hold exclude each other
   p_sel_hold_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pc_sel_o && fetch_hold_o));

   // R4/R7: a redirect lands on the target seen in the branch cycle
   p_redirect_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel_o |=> (fetch_pc_o == $past(dec_target_i)));

   // R2: otherwise the sequential address is taken
   p_sequential_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_sel_o && !fetch_hold_o) |=> (fetch_pc_o == $past(seq_pc_i)));

   // R5: a hold keeps the fetch address
   p_hold_keeps_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hold_o |=> $stable(fetch_pc_o));

   // R9: a flush leaves the all-zero word in decode
   p_flush_gives_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_flush_o |=> (dec_instr_o == '0));

   // R8: delay-slot policy never squashes or holds
   p_delay_no_squash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b10) |-> (!dec_flush_o && !fetch_hold_o));

endmodule

bind brhz_fetch_ctrl brhz_fetch_ctrl_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/brhz_fetch_ctrl_tb_top.sv
module brhz_fetch_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int IW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          take_br = 1'b0;
   logic [IW-1:0] instr;
   logic          dec_branch, dec_taken;
   logic [AW-1:0] dec_target, seq_pc;
   logic [AW-1:0] fetch_pc, next_pc;
   logic [IW-1:0] dec_instr;
   logic          pc_sel, fetch_hold, dec_flush;

   int n_checks = 0;
   int n_fails  = 0;
   int retired  = 0;
   bit mon_en   = 1'b0;
   logic [AW-1:0] exp_q[$];
   string         tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // Program: word at 0x4 is a branch to 0x40, every other word a non-zero ALU op
   function automatic logic [IW-1:0] imem(logic [AW-1:0] a);
      if (a == 32'h4) return 32'hB000_0040;
      return 32'h1000_0000 | a;
   endfunction

   assign instr      = imem(fetch_pc);
   assign dec_branch = (dec_instr[31:28] == 4'hB);
   assign dec_taken  = take_br;
   assign dec_target = {16'h0, dec_instr[15:0]};
   assign seq_pc     = fetch_pc + 32'd4;

   brhz_fetch_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .instr_i     (instr),
      .dec_branch_i(dec_branch),
      .dec_taken_i (dec_taken),
      .dec_target_i(dec_target),
      .seq_pc_i    (seq_pc),
      .fetch_pc_o  (fetch_pc),
      .dec_instr_o (dec_instr),
      .next_pc_o   (next_pc),
      .pc_sel_o    (pc_sel),
      .fetch_hold_o(fetch_hold),
      .dec_flush_o (dec_flush)
   );

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   function automatic bit is_stall(int md);
      return (md == 0 || md == 3);
   endfunction

   // Expected fetch address after the k-th clock edge following reset release
   function automatic logic [AW-1:0] exp_pc(int md, bit tk, int k);
      if (k <= 2) return AW'(4 * k);
      if (tk) return 32'h40 + AW'(4 * (k - 3));
      if (is_stall(md)) return 32'h8 + AW'(4 * (k - 3));
      return 32'hC + AW'(4 * (k - 3));
   endfunction

   function automatic string case_tag(int md, bit tk);
      if (md == 3) return "R3";
      if (md == 0) return tk ? "R4" : "R5";
      if (md == 1) return tk ? "R7" : "R6";
      return "R8";
   endfunction

   // Monitor: pops expected fetch addresses and counts retired words
   always @(negedge clk) begin
      logic [AW-1:0] e;
      string         t;
      if (mon_en && exp_q.size() > 0) begin
         if (dec_instr != '0) retired++;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(fetch_pc == e, t, "fetch pc", fetch_pc, e);
      end
   end

   // Driver: one branch scenario per policy code and outcome
   task automatic run_case(int md, bit tk);
      string tg;
      bit    stl, pnt;
      int    exp_ret;
      tg  = case_tag(md, tk);
      stl = is_stall(md);
      pnt = (md == 1);
      rst_n   = 1'b0;
      mode    = md[1:0];
      take_br = tk;
      @(negedge clk);
      @(negedge clk);
      #1;
      // R1: reset state
      check(fetch_pc == 32'h0, "R1", "reset pc", fetch_pc, 32'h0);
      check(dec_instr == '0 && !pc_sel && !fetch_hold && !dec_flush, "R1", "reset decode/ctrl",
            {dec_instr[28:0], pc_sel, fetch_hold, dec_flush}, 32'h0);
      for (int k = 1; k <= 8; k++) begin
         exp_q.push_back(exp_pc(md, tk, k));
         tag_q.push_back(k <= 2 ? "R2" : tg);
      end
      retired = 0;
      mon_en  = 1'b1;
      rst_n   = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1;
      // Branch now in decode: control outputs of this cycle
      check(pc_sel == tk, tg, "pc_sel", 32'(pc_sel), 32'(tk));
      check(fetch_hold == (stl && !tk), tg, "fetch_hold", 32'(fetch_hold), 32'(stl && !tk));
      check(dec_flush == (stl || (pnt && tk)), tg, "dec_flush", 32'(dec_flush), 32'(stl || (pnt && tk)));
      check(next_pc == (tk ? 32'h40 : 32'hC), "R10", "next_pc", next_pc, tk ? 32'h40 : 32'hC);
      @(negedge clk);
      #1;
      // R9: squashed slot is the zero word, otherwise the word at 0x8 survives
      check(dec_instr == ((stl || (pnt && tk)) ? 32'h0 : 32'h1000_0008), "R9", "word after branch",
            dec_instr, (stl || (pnt && tk)) ? 32'h0 : 32'h1000_0008);
      while (exp_q.size() != 0) @(negedge clk);
      #1;
      exp_ret = (md == 2) ? 8 : (pnt && !tk) ? 8 : 7;
      check(retired == exp_ret, tg, "retired words", 32'(retired), 32'(exp_ret));
      mon_en = 1'b0;
      rst_n  = 1'b0;
   endtask

   initial begin
      run_case(1, 1'b0);
      run_case(1, 1'b1);
      run_case(0, 1'b1);
      run_case(0, 1'b0);
      run_case(2, 1'b1);
      run_case(2, 1'b0);
      run_case(3, 1'b0);
      run_case(3, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule